// File: doc/BRIEF.md
# Dual-Lane Set-Bit Index Serializer

This block takes a 64-bit bitmap and produces the positions of all its one bits as 6-bit indices, then reports how many it produced. The word is split into a lower and an upper 32-bit half. Each half is handled by its own lane, so up to two indices leave the block per beat. Every cycle, each lane takes the lowest one bit that is left in its half and then clears it. A lane whose half has run out marks its slot invalid, and the other lane carries on without waiting.

A job enters through a valid/ready handshake. The input side is ready only while the block is idle, so a word offered during a job simply waits. Beats leave on a valid/ready stream. While the consumer holds `out_ready` low, the current beat, both lane slots included, stays frozen, and the lanes do not advance. No end marker is sent. After the last beat has been taken, a one-cycle `done` pulse carries the total index count, which a tally register has accumulated one per valid lane slot.

Top module: `bitser_top`

## Requirements
- R1: `in_ready` is 1 exactly while no job is in progress. A word is taken on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 from the next cycle until `done` has been shown.
- R2: The lower lane (`out_lo_vld`, `out_lo_idx`) emits every set bit position of `in_word[31:0]` as a value 0..31, one per accepted beat, in strictly ascending order.
- R3: The upper lane (`out_hi_vld`, `out_hi_idx`) emits every set bit position of `in_word[63:32]` as a value 32..63 (bit position plus 32), one per accepted beat, in strictly ascending order.
- R4: Both lanes advance in the same accepted beat. Once one lane has run out, its valid flag is 0 while the other lane keeps emitting. `out_valid` is 1 only when at least one lane flag is 1.
- R5: While `out_valid` is 1 and `out_ready` is 0, the beat (valid flags and indices) holds unchanged on the next cycle and no index is lost.
- R6: The number of accepted beats in a job equals the larger of the lower-half and upper-half popcounts.
- R7: `done` is 1 for exactly one cycle, the cycle right after the last beat is accepted, and `done_count` (7 bits) then equals the popcount of the whole 64-bit word.
- R8: An all-zero word produces no beats, and `done` with `done_count` = 0 in the cycle after acceptance.
- R9: After reset, `in_ready` is 1 and `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Bitmap word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_word | input | 64 | Bitmap to serialize |
| out_valid | output | 1 | Beat present on the output stream |
| out_ready | input | 1 | Consumer takes the beat on this edge |
| out_lo_vld | output | 1 | Lower-lane slot holds an index |
| out_lo_idx | output | 6 | Lower-lane index (0..31) |
| out_hi_vld | output | 1 | Upper-lane slot holds an index |
| out_hi_idx | output | 6 | Upper-lane index (32..63) |
| done | output | 1 | One-cycle end-of-job pulse |
| done_count | output | 7 | Indices emitted by the job, valid with done |

## Verification
The two functions that meet in one cycle are the two lanes: a single beat can carry a valid lower index and a valid upper index, and both have to be popped together, sometimes while the consumer is stalling that beat. The bench provokes this with random words of varied density in both halves and with a random `out_ready`. It also uses directed words whose halves have very different popcounts, so that one lane runs dry while the other is still emitting. Each slot is judged against two per-half ascending lists built by the bench. A lane slot that shows an index after its list is empty, or no index while its list still has entries, is reported.

// File: rtl/bitser_pkg.sv
package bitser_pkg;
  localparam int DEF_WORD_W = 64;
  localparam int DEF_LANES  = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bitser_state_t;
endpackage

// File: rtl/bitser_lane.sv
module bitser_lane #(
  parameter int LANE_W = 32,
  parameter int IDX_W  = 6,
  parameter int BASE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LANE_W-1:0] load_val,
  input  logic              advance,
  output logic              idx_vld,
  output logic [IDX_W-1:0]  idx
);
  localparam int SEL_W = (LANE_W > 1) ? $clog2(LANE_W) : 1;

  logic [LANE_W-1:0] rem_q;
  logic [LANE_W-1:0] iso;
  logic [SEL_W-1:0]  enc;

  // lowest one bit: value AND its two's-complement negation
  assign iso = rem_q & (~rem_q + LANE_W'(1));

  always_comb begin
    enc = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (iso[i]) enc = enc | SEL_W'(i);
    end
  end

  assign idx_vld = |rem_q;
  assign idx     = IDX_W'(BASE) + IDX_W'(enc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rem_q <= '0;
    else if (load)    rem_q <= load_val;
    else if (advance) rem_q <= rem_q ^ iso;
  end
endmodule

// File: rtl/bitser_tally.sv
module bitser_tally #(
  parameter int LANES = 2,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LANES-1:0] lane_vld,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] add;

  always_comb begin
    add = '0;
    for (int i = 0; i < LANES; i++) add = add + CNT_W'(lane_vld[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + add;
  end
endmodule

// File: rtl/bitser_ctrl.sv
module bitser_ctrl
  import bitser_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [LANES-1:0] lane_vld,
  output logic             in_ready,
  output logic             accept,
  output logic             out_valid,
  output logic             fire,
  output logic             done
);
  bitser_state_t st_q, st_d;
  logic          running, empty;

  assign running   = (st_q == ST_RUN);
  assign empty     = ~|lane_vld;
  assign in_ready  = (st_q == ST_IDLE);
  assign accept    = in_valid & in_ready;
  assign out_valid = running & ~empty;
  assign fire      = out_valid & out_ready;
  assign done      = running & empty;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_RUN;
      ST_RUN:  if (empty)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/bitser_top.sv
module bitser_top
  import bitser_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int LANES  = DEF_LANES,
  localparam int LANE_W = WORD_W / LANES,
  localparam int IDX_W  = $clog2(WORD_W),
  localparam int CNT_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_lo_vld,
  output logic [IDX_W-1:0]  out_lo_idx,
  output logic              out_hi_vld,
  output logic [IDX_W-1:0]  out_hi_idx,
  output logic              done,
  output logic [CNT_W-1:0]  done_count
);
  logic [LANES-1:0] lane_vld;
  logic [IDX_W-1:0] lane_idx [LANES];
  logic             accept, fire;
  logic [CNT_W-1:0] tally;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bitser_lane #(
      .LANE_W (LANE_W),
      .IDX_W  (IDX_W),
      .BASE   (g * LANE_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (in_word[g*LANE_W +: LANE_W]),
      .advance  (fire),
      .idx_vld  (lane_vld[g]),
      .idx      (lane_idx[g])
    );
  end

  bitser_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .lane_vld  (lane_vld),
    .in_ready  (in_ready),
    .accept    (accept),
    .out_valid (out_valid),
    .fire      (fire),
    .done      (done)
  );

  bitser_tally #(.LANES(LANES), .CNT_W(CNT_W)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .step     (fire),
    .lane_vld (lane_vld),
    .count    (tally)
  );

  assign out_lo_vld = out_valid & lane_vld[0];
  assign out_lo_idx = lane_idx[0];
  assign out_hi_vld = out_valid & lane_vld[LANES-1];
  assign out_hi_idx = lane_idx[LANES-1];
  assign done_count = done ? tally : '0;
endmodule

// File: rtl/bitser_checker.sv
module bitser_checker #(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_lo_vld,
  input logic [IDX_W-1:0] out_lo_idx,
  input logic             out_hi_vld,
  input logic [IDX_W-1:0] out_hi_idx,
  input logic             done,
  input logic [CNT_W-1:0] done_count
);
  localparam int HALF = WORD_W / 2;

  assert_take_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_done_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  assert_lo_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_lo_vld |-> (int'(out_lo_idx) < HALF));
  assert_lo_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_lo_vld) ##1 (out_valid && out_ready && out_lo_vld)
      |-> (out_lo_idx > $past(out_lo_idx)));
  assert_hi_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_hi_vld |-> (int'(out_hi_idx) >= HALF));
  assert_hi_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_hi_vld) ##1 (out_valid && out_ready && out_hi_vld)
      |-> (out_hi_idx > $past(out_hi_idx)));
  assert_beat_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lo_vld || out_hi_vld));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo_vld) && $stable(out_hi_vld)
      && $stable(out_lo_idx) && $stable(out_hi_idx)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_count_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(done_count) <= WORD_W));
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

bind bitser_top bitser_checker #(
  .WORD_W (WORD_W),
  .IDX_W  (IDX_W),
  .CNT_W  (CNT_W)
) u_bitser_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_lo_vld (out_lo_vld),
  .out_lo_idx (out_lo_idx),
  .out_hi_vld (out_hi_vld),
  .out_hi_idx (out_hi_idx),
  .done       (done),
  .done_count (done_count)
);

// File: tb/bitser_top_test.sv
module bitser_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_lo_vld, out_hi_vld;
  logic [5:0]  out_lo_idx, out_hi_idx;
  logic        done;
  logic [6:0]  done_count;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitser_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_lo_vld(out_lo_vld), .out_lo_idx(out_lo_idx),
    .out_hi_vld(out_hi_vld), .out_hi_idx(out_hi_idx),
    .done(done), .done_count(done_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int popc32(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic run_job(input logic [63:0] w, input int rdy_pct);
    int lo_exp[32];
    int hi_exp[32];
    int nlo = 0, nhi = 0, plo = 0, phi = 0, beats = 0, waitc = 0;
    bit stalled = 0, finished = 0;
    logic [13:0] held = '0;
    for (int i = 0; i < 32; i++) begin
      if (w[i])      begin lo_exp[nlo] = i;      nlo++; end
      if (w[32 + i]) begin hi_exp[nhi] = 32 + i; nhi++; end
    end
    while (!in_ready && waitc < 100) begin @(negedge clk); waitc++; end
    check(in_ready === 1'b1, "R1", "in_ready when idle", longint'(in_ready), 1);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = $urandom;
    for (int it = 0; it < 400 && !finished; it++) begin
      if (done) begin
        check(beats == ((nlo > nhi) ? nlo : nhi), "R6", "beat total", beats,
              (nlo > nhi) ? nlo : nhi);
        check(plo == nlo && phi == nhi, "R7", "indices drained", plo + phi, nlo + nhi);
        check(int'(done_count) == popc32(w[31:0]) + popc32(w[63:32]), (w == 0) ? "R8" : "R7",
              "done_count", done_count, popc32(w[31:0]) + popc32(w[63:32]));
        check(in_ready === 1'b0, "R1", "in_ready with done", in_ready, 0);
        out_ready = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R7", "done width", done, 0);
        check(in_ready === 1'b1, "R1", "in_ready after done", in_ready, 1);
        finished = 1;
      end else begin
        if (plo == nlo && phi == nhi) begin
          check(1'b0, (w == 0) ? "R8" : "R7", "done after last beat", done, 1);
          finished = 1;
        end else begin
          check(out_valid === 1'b1 && in_ready === 1'b0, "R4", "beat present",
                out_valid, 1);
          check(out_lo_vld === (plo < nlo), "R4", "lo slot flag", out_lo_vld, plo < nlo);
          if (plo < nlo)
            check(int'(out_lo_idx) == lo_exp[plo], "R2", "lo index", out_lo_idx, lo_exp[plo]);
          check(out_hi_vld === (phi < nhi), "R4", "hi slot flag", out_hi_vld, phi < nhi);
          if (phi < nhi)
            check(int'(out_hi_idx) == hi_exp[phi], "R3", "hi index", out_hi_idx, hi_exp[phi]);
          if (stalled)
            check({out_lo_vld, out_lo_idx, out_hi_vld, out_hi_idx} == held, "R5",
                  "held beat", {out_lo_vld, out_lo_idx, out_hi_vld, out_hi_idx}, held);
          out_ready = (($urandom % 100) < rdy_pct);
          if (out_ready) begin
            if (out_lo_vld) plo++;
            if (out_hi_vld) phi++;
            beats++;
            stalled = 0;
          end else begin
            stalled = 1;
            held = {out_lo_vld, out_lo_idx, out_hi_vld, out_hi_idx};
          end
          @(negedge clk);
        end
      end
    end
    check(finished, "R7", "job finished", finished, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R7 watchdog expired: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1, "R9", "in_ready in reset", in_ready, 1);
    check(out_valid === 1'b0 && done === 1'b0, "R9", "quiet in reset", out_valid | done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R9", "idle after reset", in_ready, 1);
    run_job(64'h0, 100);                       // R8
    run_job(64'hFFFF_FFFF_FFFF_FFFF, 100);     // R6 full
    run_job(64'h0000_0001_8000_0000, 100);     // R2 bit 31, R3 bit 32
    run_job(64'h8000_0000_0000_0001, 100);
    run_job(64'h0000_0000_0000_00F5, 60);      // only low lane
    run_job(64'hA500_0000_0000_0000, 60);      // only high lane
    run_job(64'h0000_0003_FFFF_0000, 40);      // lanes run out unevenly
    run_job(64'hFFFF_FFFF_FFFF_FFFF, 30);      // stalls on double beats
    run_job(64'h0, 0);
    for (int j = 0; j < 60; j++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      if (j % 3 == 1) w = w & {$urandom, $urandom};
      if (j % 3 == 2) w = w | {$urandom, $urandom};
      run_job(w, 30 + (j % 4) * 20);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule